// File: doc/BRIEF.md
# DC Offset Removal Filter

The block removes the slowly varying DC component from two streams of 14-bit signed converter samples. Each channel runs a first-order leaky integrator. On every tracked sample the integrator moves its DC estimate toward the incoming sample by the fraction 2^-(k+14), where k is a 4-bit bandwidth code. The corner frequency is therefore 2^-(k+14) · fs / (2π).

One 7-bit control word drives both channels. It switches tracking on, applies the estimate to the output stream, freezes the estimate, and selects the bandwidth. When tracking is on and the correction is not applied, downstream monitoring logic can still read the estimate while the samples pass through untouched. The estimate of each channel is always visible as a 14-bit readback.

Top module: `dcOffsetFilter`

## Requirements
- R1: The control word fields are: bit 0 track enable, bit 1 apply correction, bits [5:2] bandwidth code k (unsigned), and bit 6 freeze.
- R2: Codes k = 14 and k = 15 behave exactly like k = 13.
- R3: The integrator holds 41 bits, of which 27 are fractional. On a tracked sample x it adds (x − est) · 2^(13−k) in fractional units. The readback est is the top 14 bits, which is the floor of the integrator value, as a signed number.
- R4: The estimate changes only on a cycle where sample valid is high, track enable is 1 and freeze is 0. When freeze is cleared, tracking resumes from the held value.
- R5: With apply set, the output is x − est, where est is the estimate in that cycle before it is updated. With apply clear, the output equals x exactly.
- R6: The corrected output saturates to the range [−8192, 8191] and never wraps.
- R7: Each valid sample produces its output one clock later, with out valid high. When sample valid is low, out valid is low and the outputs and the estimates hold.
- R8: A synchronous reset clears both estimates, both outputs and out valid to zero.
- R9: The two channels share the control word but keep independent integrators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrlWord | input | 7 | Shared control fields (R1) |
| sampleValid | input | 1 | Qualifies sampleA and sampleB |
| sampleA | input | 14 | Channel A sample, two's complement |
| sampleB | input | 14 | Channel B sample, two's complement |
| outValid | output | 1 | Output samples valid |
| outA | output | 14 | Channel A output sample |
| outB | output | 14 | Channel B output sample |
| estA | output | 14 | Channel A DC estimate readback |
| estB | output | 14 | Channel B DC estimate readback |

## Verification
On every cycle the assertions check these behaviours:
- The estimate holds whenever no tracked sample arrives or freeze is set.
- The estimate never moves away from the current sample.
- Bypass returns the sample bit-exact.
- A sign-safe correction never wraps.
- Out valid follows sample valid by exactly one cycle.
- The internal bandwidth code never exceeds 13.

Only the bench's scenarios can show the exact integrator arithmetic. These cover the floor behaviour of the readback, the equivalence of codes 14 and 15 to 13 over a long run, independence between the two channels, and saturation, which occurs only after an estimate has been driven far toward one rail.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int K_W    = 4;
  localparam int CTRL_W = 7;
  // control word field positions
  localparam int BIT_TRACK  = 0;
  localparam int BIT_APPLY  = 1;
  localparam int BIT_K_LO   = 2;
  localparam int BIT_FREEZE = 6;

  typedef struct packed {
    logic           sampleEn;
    logic           track;
    logic           apply;
    logic [K_W-1:0] shift;
  } dcfStrobes_t;
endpackage

// File: rtl/dcfControl.sv
module dcfControl
  import dcf_pkg::*;
#(
  parameter int KMAX = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              validIn,
  output dcfStrobes_t       strobes,
  output logic              outValid
);
  logic [K_W-1:0] kRaw;

  assign kRaw = ctrlWord[BIT_K_LO +: K_W];

  always_comb begin
    strobes.sampleEn = validIn;
    strobes.track    = validIn & ctrlWord[BIT_TRACK] & ~ctrlWord[BIT_FREEZE];
    strobes.apply    = ctrlWord[BIT_APPLY];
    strobes.shift    = (kRaw > K_W'(KMAX)) ? K_W'(KMAX) : kRaw;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= validIn;
  end

  // R7: out valid trails sample valid by one cycle
  a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
    validIn |=> outValid);
  a_r7_valid_low: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !outValid);
  // R2: internal bandwidth code is capped
  a_r2_shift_cap: assert property (@(posedge clk) disable iff (rst)
    strobes.shift <= K_W'(KMAX));
endmodule

// File: rtl/dcfChannel.sv
module dcfChannel
  import dcf_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int FRAC_W    = 27,
  parameter int GAIN_BASE = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dcfStrobes_t              strobes,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] outSample,
  output logic signed [DATA_W-1:0] estimate
);
  localparam int ACC_W  = DATA_W + FRAC_W;
  localparam int SUM_W  = ACC_W + 1;
  localparam int ERR_W  = DATA_W + 1;
  localparam int TOP_SH = FRAC_W - GAIN_BASE;
  localparam int SH_W   = $clog2(TOP_SH + 1);
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  acc;
  logic signed [ERR_W-1:0]  err;
  logic [SH_W-1:0]          shAmt;
  logic signed [SUM_W-1:0]  step;
  logic signed [SUM_W-1:0]  accSum;
  logic signed [DATA_W-1:0] corrected;
  logic signed [DATA_W-1:0] outNext;

  assign estimate = acc[ACC_W-1 -: DATA_W];

  always_comb begin
    err    = ERR_W'(sampleIn) - ERR_W'(estimate);
    shAmt  = SH_W'(TOP_SH) - SH_W'(strobes.shift);
    step   = SUM_W'(err) <<< shAmt;
    accSum = SUM_W'(acc) + step;
    if (err[ERR_W-1] != err[ERR_W-2])
      corrected = err[ERR_W-1] ? MINV : MAXV;
    else
      corrected = err[DATA_W-1:0];
    outNext = strobes.apply ? corrected : sampleIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      outSample <= '0;
    end else begin
      if (strobes.sampleEn) outSample <= outNext;
      if (strobes.track)    acc       <= accSum[ACC_W-1:0];
    end
  end

  // R4: estimate holds without a tracked sample
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.track |=> $stable(estimate));
  // R3: estimate never moves away from the sample
  a_r3_toward_up: assert property (@(posedge clk) disable iff (rst)
    strobes.track && (sampleIn >= estimate) |=>
      (estimate >= $past(estimate)) && (estimate <= $past(sampleIn)));
  a_r3_toward_dn: assert property (@(posedge clk) disable iff (rst)
    strobes.track && (sampleIn < estimate) |=> estimate <= $past(estimate));
  // R5: bypass is bit-exact
  a_r5_bypass: assert property (@(posedge clk) disable iff (rst)
    strobes.sampleEn && !strobes.apply |=> outSample == $past(sampleIn));
  // R6: correction of a non-negative sample by a non-positive estimate stays non-negative
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    strobes.sampleEn && strobes.apply && (sampleIn >= 0) && (estimate <= 0)
      |=> outSample >= 0);
endmodule

// File: rtl/dcOffsetFilter.sv
module dcOffsetFilter
  import dcf_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int FRAC_W    = 27,
  parameter int GAIN_BASE = 14,
  parameter int KMAX      = 13,
  parameter int NUM_CH    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [6:0]               ctrlWord,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleA,
  input  logic signed [DATA_W-1:0] sampleB,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outA,
  output logic signed [DATA_W-1:0] outB,
  output logic signed [DATA_W-1:0] estA,
  output logic signed [DATA_W-1:0] estB
);
  dcfStrobes_t strobes;
  logic signed [DATA_W-1:0] chIn  [NUM_CH];
  logic signed [DATA_W-1:0] chOut [NUM_CH];
  logic signed [DATA_W-1:0] chEst [NUM_CH];

  assign chIn[0] = sampleA;
  assign chIn[1] = sampleB;

  dcfControl #(.KMAX(KMAX)) i_ctrl (
    .clk(clk), .rst(rst), .ctrlWord(ctrlWord), .validIn(sampleValid),
    .strobes(strobes), .outValid(outValid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcfChannel #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .GAIN_BASE(GAIN_BASE)) i_chan (
      .clk(clk), .rst(rst), .strobes(strobes), .sampleIn(chIn[c]),
      .outSample(chOut[c]), .estimate(chEst[c])
    );
  end

  assign outA = chOut[0];
  assign outB = chOut[1];
  assign estA = chEst[0];
  assign estB = chEst[1];

  // R4: freeze bit keeps both readbacks steady
  a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
    ctrlWord[BIT_FREEZE] |=> $stable(estA) && $stable(estB));
  // R1: with track enable clear the estimates stay put
  a_r1_no_track: assert property (@(posedge clk) disable iff (rst)
    !ctrlWord[BIT_TRACK] |=> $stable(estA) && $stable(estB));
endmodule

// File: tb/test_dcOffsetFilter.sv
`timescale 1ns/1ps
module test_dcOffsetFilter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] ctrlWord = '0;
  logic sampleValid = 1'b0;
  logic signed [13:0] sampleA = '0, sampleB = '0;
  logic outValid;
  logic signed [13:0] outA, outB, estA, estB;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  longint accM [2];
  longint outM [2];

  always #2 clk = ~clk;

  dcOffsetFilter i_dcOffsetFilter (
    .clk(clk), .rst(rst), .ctrlWord(ctrlWord), .sampleValid(sampleValid),
    .sampleA(sampleA), .sampleB(sampleB), .outValid(outValid),
    .outA(outA), .outB(outB), .estA(estA), .estB(estB)
  );

  function automatic longint estOf(longint a);
    return a >>> 27;
  endfunction

  function automatic longint sat14(longint v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  task automatic check(string req, longint got, longint exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, model, sample 1 ns after the edge
  task automatic step(logic [6:0] cw, logic v, longint xa, longint xb, string req);
    longint xs [2];
    longint e, k;
    bit expValid;
    xs[0] = xa; xs[1] = xb;
    @(negedge clk);
    ctrlWord = cw; sampleValid = v;
    sampleA = 14'(xa); sampleB = 14'(xb);
    k = longint'(cw[5:2]);
    if (k > 13) k = 13;
    for (int c = 0; c < 2; c++) begin
      e = estOf(accM[c]);
      if (v) outM[c] = cw[1] ? sat14(xs[c] - e) : xs[c];
      if (v && cw[0] && !cw[6]) accM[c] = accM[c] + ((xs[c] - e) <<< (13 - k));
    end
    expValid = v;
    @(posedge clk); #1;
    check(req, longint'(outValid), longint'(expValid));
    check(req, longint'(outA), outM[0]);
    check(req, longint'(outB), outM[1]);
    check(req, longint'(estA), estOf(accM[0]));
    check(req, longint'(estB), estOf(accM[1]));
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; sampleValid = 1'b0;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    accM[0] = 0; accM[1] = 0; outM[0] = 0; outM[1] = 0;
  endtask

  function automatic logic [6:0] cwOf(bit en, bit ap, int k, bit frz);
    return {frz, 4'(k), ap, en};
  endfunction

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    accM[0] = 0; accM[1] = 0; outM[0] = 0; outM[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check("R8", longint'(outValid), 0);
    check("R8", longint'(estA), 0);
    check("R8", longint'(outB), 0);
    doReset();

    // R3 R2 R9: sweep every bandwidth code with different patterns per channel
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 150; i++) begin
        longint xa = 3000 + ((i * 37 + k * 11) % 900) - 450;
        longint xb = -2500 + ((i * 53) % 1200) - 600;
        step(cwOf(1, 1, k, 0), (i % 7) != 6, xa, xb, "R3");
      end
    end

    // R2: code 14 and 15 against 13 from a common nonzero state
    for (int k = 13; k < 16; k++) begin
      doReset();
      for (int i = 0; i < 300; i++) step(cwOf(1, 1, 0, 0), 1, 5000, -7000, "R2");
      for (int i = 0; i < 200; i++) step(cwOf(1, 1, k, 0), 1, -6000 + i, 6000 - i, "R2");
    end

    // R4: freeze holds, then resumes from held value
    doReset();
    for (int i = 0; i < 400; i++) step(cwOf(1, 1, 0, 0), 1, 4000, -4000, "R4");
    for (int i = 0; i < 100; i++) step(cwOf(1, 1, 0, 1), 1, -8000 + i * 50, 8000 - i * 60, "R4");
    for (int i = 0; i < 100; i++) step(cwOf(1, 1, 1, 0), 1, -3000, 3000, "R4");
    // R1: track disabled keeps estimate, apply still uses it
    for (int i = 0; i < 100; i++) step(cwOf(0, 1, 0, 0), 1, i * 80 - 4000, 4000 - i * 80, "R1");
    // R5: bypass, including rails
    for (int i = 0; i < 64; i++) step(cwOf(1, 0, 2, 0), 1, (i * 257) % 16384 - 8192, 8191 - i, "R5");
    step(cwOf(1, 0, 2, 0), 1, 8191, -8192, "R5");
    // R7: idle cycles hold outputs and estimates
    for (int i = 0; i < 20; i++) step(cwOf(1, 1, 0, 0), 0, 1234, -1234, "R7");

    // R6: drive estimates toward opposite rails then hit the other rail
    doReset();
    for (int i = 0; i < 12000; i++) step(cwOf(1, 0, 0, 0), 1, -8192, 8191, "R6");
    for (int i = 0; i < 30; i++) step(cwOf(0, 1, 0, 0), 1, 8191 - i * 3, -8192 + i * 3, "R6");
    check("R6", longint'(outA), 8191);
    check("R6", longint'(outB), -8192);

    // R8: reset mid-stream clears everything
    doReset();
    #1;
    check("R8", longint'(estA), 0);
    check("R8", longint'(estB), 0);
    check("R8", longint'(outA), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule